// File: doc/BRIEF.md
# Translation Invalidation Privilege Gate

This block is the decode-and-permission stage for a supervisor instruction that drops cached address translations. Each cycle that `insn_valid` is high it takes the 32-bit instruction word together with the hart's current privilege mode and its virtualization controls. It extracts the two source register indices and checks the privilege rules in a fixed order. One cycle later it presents exactly one outcome: a one-hot trap cause (illegal instruction or virtual instruction), or a single-cycle invalidation request.

A request tells the translation cache which entries to drop. It carries a scope code derived from which register indices are zero, a flag that marks guest (virtualized supervisor) scope, and the guest VMID when that flag is set. It also echoes the register indices, so the next stage can read the address and ASID operands. Register-file reads, trap delivery and the translation cache itself lie outside this block.

The instruction word is assumed to have been recognized as this instruction already, so no opcode check is made. The parameter `STRICT_VS` selects how VS mode is handled. With the default value of 1, VS mode always takes the illegal-instruction trap. With 0, VS mode is gated only by the virtual trap bit.

Top module: `tinv_gate`

## Requirements
- R1: On a request, `req_rs1` equals instruction bits [19:15] and `req_rs2` equals instruction bits [24:20].
- R2: `req_scope` is 0 (everything) when both indices are zero, 1 (one ASID) when only rs2 is nonzero, 2 (one address) when only rs1 is nonzero, and 3 (ASID and address) when both are nonzero.
- R3: Mode S (encoding 1) with the trap-VM bit set gives an illegal-instruction trap (`trap_cause` = 2'b01). Mode S with the bit clear issues a request.
- R4: With `STRICT_VS`=1, mode VS (encoding 3) always gives an illegal-instruction trap, even when the conditions for a virtual-instruction trap also hold.
- R5: With `STRICT_VS`=0, mode VS with the hypervisor present and the virtual trap bit set gives a virtual-instruction trap (`trap_cause` = 2'b10). An illegal-instruction trap takes priority over it.
- R6: Mode U (encoding 2) and the undefined mode encodings 5 to 7 always give an illegal-instruction trap.
- R7: Mode VU (encoding 4) gives a virtual-instruction trap when the hypervisor is present. Without the hypervisor it issues a supervisor-scope request.
- R8: A request issued from VS mode with the hypervisor present has `req_guest`=1 and `req_vmid` equal to `guest_vmid`. Any other request has `req_guest`=0 and `req_vmid`=0.
- R9: Mode M (encoding 0) never traps, whatever the control bits are.
- R10: Each accepted instruction produces its outcome exactly one cycle later, for one cycle. Request and trap are never both present, `trap_cause` is at most one-hot, and every output is zero in a cycle that follows an idle input.
- R11: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| priv_mode | input | 3 | Current mode: 0 M, 1 S, 2 U, 3 VS, 4 VU |
| trap_vm | input | 1 | Supervisor trap-VM control bit |
| hyp_present | input | 1 | Hypervisor support is enabled |
| vtrap_vm | input | 1 | Virtual trap-VM control bit |
| guest_vmid | input | VMID_W | Current guest VMID from the guest translation register |
| req_valid | output | 1 | Invalidation request pulse |
| req_scope | output | 2 | Invalidation scope code (R2) |
| req_guest | output | 1 | Request targets guest translations |
| req_vmid | output | VMID_W | VMID for a guest request, else zero |
| req_rs1 | output | 5 | Address operand register index |
| req_rs2 | output | 5 | ASID operand register index |
| trap_cause | output | 2 | One-hot trap: bit 0 illegal, bit 1 virtual |

## Verification
Assertions check several properties on every cycle: the outcome is exclusive and at most one-hot, every outcome follows an accepted instruction, machine mode always issues a request, user mode and trap-VM-set supervisor mode always trap, a global scope carries zero indices, and host requests carry a zero VMID. The bench scenarios cover what those properties cannot: the exact field positions, every scope code, the priority between competing traps in VS mode, the VU-mode outcome with and without a hypervisor, and guest marking. The guest-marking and virtual-trap cases need a second instance built with `STRICT_VS`=0.

// File: rtl/tinv_pkg.sv
// Package: shared encodings for the translation invalidation gate.
// Assumes the privilege mode arrives as a 3-bit code, with 5..7 unused.
package tinv_pkg;

    typedef enum logic [2:0] {
        PRV_M  = 3'd0,
        PRV_S  = 3'd1,
        PRV_U  = 3'd2,
        PRV_VS = 3'd3,
        PRV_VU = 3'd4
    } prv_e;

    typedef enum logic [1:0] {
        SCOPE_ALL  = 2'd0,
        SCOPE_ASID = 2'd1,
        SCOPE_ADDR = 2'd2,
        SCOPE_BOTH = 2'd3
    } scope_e;

    localparam int CAUSE_W    = 2;
    localparam int CAUSE_ILL  = 0;
    localparam int CAUSE_VIRT = 1;
    localparam int REGIDX_W   = 5;
    localparam int RS1_LSB    = 15;
    localparam int RS2_LSB    = 20;

endpackage

// File: rtl/tinv_field_decode.sv
// Module: extracts the two source register indices and derives the
// invalidation scope from which of them are zero.
// Assumes the word is already known to be the invalidate instruction.
module tinv_field_decode
    import tinv_pkg::*;
#(
    parameter int INSN_W = 32
) (
    input  logic [INSN_W-1:0]   insn,
    output logic [REGIDX_W-1:0] rs1,
    output logic [REGIDX_W-1:0] rs2,
    output logic [1:0]          scope
);

    logic unused_insn_bits;

    // Slice the register index fields out of the word.
    always_comb begin
        rs1 = insn[RS1_LSB +: REGIDX_W];
        rs2 = insn[RS2_LSB +: REGIDX_W];
    end

    // A nonzero rs1 narrows to one address; a nonzero rs2 narrows to one ASID.
    always_comb begin
        if (rs1 == '0 && rs2 == '0)      scope = SCOPE_ALL;
        else if (rs1 == '0)              scope = SCOPE_ASID;
        else if (rs2 == '0)              scope = SCOPE_ADDR;
        else                             scope = SCOPE_BOTH;
    end

    assign unused_insn_bits = ^{insn[INSN_W-1:RS2_LSB+REGIDX_W], insn[RS1_LSB-1:0]};

endmodule

// File: rtl/tinv_priv_check.sv
// Module: ordered privilege checks. Only the first trap that matches is
// reported, as a one-hot cause. With no trap, it also reports whether
// the request targets guest translations.
// Assumes that mode codes 5..7 are never legal.
module tinv_priv_check
    import tinv_pkg::*;
#(
    parameter bit STRICT_VS = 1'b1
) (
    input  logic [2:0]         priv_mode,
    input  logic               trap_vm,
    input  logic               hyp_present,
    input  logic               vtrap_vm,
    output logic [CAUSE_W-1:0] cause,
    output logic               guest
);

    logic mode_s, mode_u, mode_vs, mode_vu, mode_bad;

    // Decode the mode code into single-bit flags.
    always_comb begin
        mode_s   = (priv_mode == PRV_S);
        mode_u   = (priv_mode == PRV_U);
        mode_vs  = (priv_mode == PRV_VS);
        mode_vu  = (priv_mode == PRV_VU);
        mode_bad = (priv_mode > PRV_VU);
    end

    // Walk the trap checks in priority order; the first match wins.
    always_comb begin
        cause = '0;
        if ((trap_vm && mode_s) || (STRICT_VS && mode_vs))
            cause[CAUSE_ILL] = 1'b1;
        else if (hyp_present && vtrap_vm && mode_vs)
            cause[CAUSE_VIRT] = 1'b1;
        else if (mode_u || mode_bad)
            cause[CAUSE_ILL] = 1'b1;
        else if (hyp_present && mode_vu)
            cause[CAUSE_VIRT] = 1'b1;
    end

    // A guest request comes only from VS mode with the hypervisor present.
    always_comb guest = hyp_present && mode_vs;

endmodule

// File: rtl/tinv_gate.sv
// Module: top of the translation invalidation gate. It registers the
// outcome of the field decode and the privilege check, so each accepted
// instruction yields one request or one trap a cycle later.
// Assumes insn_valid is only raised for the invalidate instruction.
module tinv_gate
    import tinv_pkg::*;
#(
    parameter int INSN_W    = 32,
    parameter int VMID_W    = 14,
    parameter bit STRICT_VS = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                insn_valid,
    input  logic [INSN_W-1:0]   insn,
    input  logic [2:0]          priv_mode,
    input  logic                trap_vm,
    input  logic                hyp_present,
    input  logic                vtrap_vm,
    input  logic [VMID_W-1:0]   guest_vmid,
    output logic                req_valid,
    output logic [1:0]          req_scope,
    output logic                req_guest,
    output logic [VMID_W-1:0]   req_vmid,
    output logic [REGIDX_W-1:0] req_rs1,
    output logic [REGIDX_W-1:0] req_rs2,
    output logic [CAUSE_W-1:0]  trap_cause
);

    logic [REGIDX_W-1:0] dec_rs1, dec_rs2;
    logic [1:0]          dec_scope;
    logic [CAUSE_W-1:0]  chk_cause;
    logic                chk_guest;
    logic                issue;

    tinv_field_decode #(.INSN_W(INSN_W)) u_dec (
        .insn  (insn),
        .rs1   (dec_rs1),
        .rs2   (dec_rs2),
        .scope (dec_scope)
    );

    tinv_priv_check #(.STRICT_VS(STRICT_VS)) u_chk (
        .priv_mode   (priv_mode),
        .trap_vm     (trap_vm),
        .hyp_present (hyp_present),
        .vtrap_vm    (vtrap_vm),
        .cause       (chk_cause),
        .guest       (chk_guest)
    );

    // A request is issued when an instruction is present and nothing traps.
    always_comb issue = insn_valid && (chk_cause == '0);

    // Register the outcome; request fields stay zero unless a request issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid  <= 1'b0;
            req_scope  <= '0;
            req_guest  <= 1'b0;
            req_vmid   <= '0;
            req_rs1    <= '0;
            req_rs2    <= '0;
            trap_cause <= '0;
        end else begin
            req_valid  <= issue;
            trap_cause <= insn_valid ? chk_cause : '0;
            req_scope  <= issue ? dec_scope : '0;
            req_rs1    <= issue ? dec_rs1 : '0;
            req_rs2    <= issue ? dec_rs2 : '0;
            req_guest  <= issue && chk_guest;
            req_vmid   <= (issue && chk_guest) ? guest_vmid : '0;
        end
    end

    // R10: an outcome appears only after an accepted instruction.
    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || (trap_cause != '0)) |-> $past(insn_valid));

    // R10: request and trap never coincide.
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (trap_cause != '0)));

    // R10: at most one trap cause.
    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trap_cause));

    // R9: machine mode always issues.
    p_mmode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && priv_mode == PRV_M) |=> req_valid);

    // R6: user mode is always illegal.
    p_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && priv_mode == PRV_U) |=> (trap_cause == 2'b01));

    // R3: supervisor mode with trap-VM set is illegal.
    p_s_tvm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && priv_mode == PRV_S && trap_vm) |=> (trap_cause == 2'b01));

    // R2: a global scope comes only from two zero indices.
    p_scope_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_scope == SCOPE_ALL) |-> (req_rs1 == '0 && req_rs2 == '0));

    // R8: host requests carry no VMID.
    p_host_vmid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_guest) |-> (req_vmid == '0));

    generate
        if (STRICT_VS) begin : g_strict
            // R4: VS mode is always illegal in the strict variant.
            p_vs_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (insn_valid && priv_mode == PRV_VS) |=> (trap_cause == 2'b01));
        end
    endgenerate

endmodule

// File: tb/tb_tinv_gate.sv
`timescale 1ns/1ps
module tb_tinv_gate;

    localparam int VMID_W = 14;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              insn_valid;
    logic [31:0]       insn;
    logic [2:0]        priv_mode;
    logic              trap_vm, hyp_present, vtrap_vm;
    logic [VMID_W-1:0] guest_vmid;

    logic              a_req, g_req;
    logic [1:0]        a_scope, g_scope;
    logic              a_guest, g_guest;
    logic [VMID_W-1:0] a_vmid, g_vmid;
    logic [4:0]        a_rs1, a_rs2, g_rs1, g_rs2;
    logic [1:0]        a_cause, g_cause;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tinv_gate #(.VMID_W(VMID_W), .STRICT_VS(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .priv_mode(priv_mode), .trap_vm(trap_vm), .hyp_present(hyp_present),
        .vtrap_vm(vtrap_vm), .guest_vmid(guest_vmid),
        .req_valid(a_req), .req_scope(a_scope), .req_guest(a_guest),
        .req_vmid(a_vmid), .req_rs1(a_rs1), .req_rs2(a_rs2), .trap_cause(a_cause)
    );

    tinv_gate #(.VMID_W(VMID_W), .STRICT_VS(1'b0)) dut_g (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .priv_mode(priv_mode), .trap_vm(trap_vm), .hyp_present(hyp_present),
        .vtrap_vm(vtrap_vm), .guest_vmid(guest_vmid),
        .req_valid(g_req), .req_scope(g_scope), .req_guest(g_guest),
        .req_vmid(g_vmid), .req_rs1(g_rs1), .req_rs2(g_rs2), .trap_cause(g_cause)
    );

    // Compare one instance's outputs with expected values.
    task automatic expect_out(input string tag, input bit use_g, input bit e_req,
                              input logic [1:0] e_cause, input logic [1:0] e_scope,
                              input bit e_guest, input logic [VMID_W-1:0] e_vmid,
                              input logic [4:0] e_rs1, input logic [4:0] e_rs2);
        logic [VMID_W+15:0] act, exp;
        act = use_g ? {g_req, g_cause, g_scope, g_guest, g_vmid, g_rs1, g_rs2}
                    : {a_req, a_cause, a_scope, a_guest, a_vmid, a_rs1, a_rs2};
        exp = {e_req, e_cause, e_scope, e_guest, e_vmid, e_rs1, e_rs2};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got req=%0b cause=%b scope=%0d guest=%0b vmid=%0h rs1=%0d rs2=%0d, expected req=%0b cause=%b scope=%0d guest=%0b vmid=%0h rs1=%0d rs2=%0d",
                     tag, act[VMID_W+15], act[VMID_W+14:VMID_W+13], act[VMID_W+12:VMID_W+11],
                     act[VMID_W+10], act[VMID_W+9:10], act[9:5], act[4:0],
                     e_req, e_cause, e_scope, e_guest, e_vmid, e_rs1, e_rs2);
        end
    endtask

    // Present one instruction for a cycle; outputs are then read at the next negedge.
    task automatic issue(input logic [2:0] m, input bit tvm, input bit hyp, input bit vtvm,
                         input logic [4:0] r1, input logic [4:0] r2);
        @(negedge clk);
        insn        = {7'b0001011, r2, r1, 3'b000, 5'b00000, 7'b1110011};
        priv_mode   = m;
        trap_vm     = tvm;
        hyp_present = hyp;
        vtrap_vm    = vtvm;
        insn_valid  = 1'b1;
        @(negedge clk);
        insn_valid  = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; insn_valid = 1'b1; insn = 32'hFFFF_FFFF; priv_mode = 3'd0;
        trap_vm = 1'b0; hyp_present = 1'b1; vtrap_vm = 1'b0; guest_vmid = 14'h2A5;
        repeat (3) @(negedge clk);
        expect_out("R11 reset outputs zero", 1'b0, 0, 2'b00, 2'd0, 0, '0, 5'd0, 5'd0);
        insn_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_scopes;
        issue(3'd0, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0);
        expect_out("R2 R9 global scope in M with tvm", 1'b0, 1, 2'b00, 2'd0, 0, '0, 5'd0, 5'd0);
        issue(3'd0, 1'b0, 1'b1, 1'b1, 5'd0, 5'd9);
        expect_out("R2 R1 asid scope", 1'b0, 1, 2'b00, 2'd1, 0, '0, 5'd0, 5'd9);
        issue(3'd1, 1'b0, 1'b0, 1'b0, 5'd17, 5'd0);
        expect_out("R2 R3 address scope from S", 1'b0, 1, 2'b00, 2'd2, 0, '0, 5'd17, 5'd0);
        issue(3'd0, 1'b0, 1'b0, 1'b0, 5'd31, 5'd1);
        expect_out("R2 R1 both scope", 1'b0, 1, 2'b00, 2'd3, 0, '0, 5'd31, 5'd1);
    endtask

    task automatic t_supervisor;
        issue(3'd1, 1'b1, 1'b1, 1'b1, 5'd4, 5'd6);
        expect_out("R3 S with trap-VM illegal", 1'b0, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
        expect_out("R3 S with trap-VM illegal (variant)", 1'b1, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
    endtask

    task automatic t_vs_mode;
        issue(3'd3, 1'b0, 1'b1, 1'b1, 5'd2, 5'd3);
        expect_out("R4 strict VS illegal over virtual", 1'b0, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
        expect_out("R5 VS virtual trap", 1'b1, 0, 2'b10, 2'd0, 0, '0, 5'd0, 5'd0);
        issue(3'd3, 1'b0, 1'b1, 1'b0, 5'd2, 5'd3);
        expect_out("R4 strict VS illegal, vtvm clear", 1'b0, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
        expect_out("R8 VS guest request", 1'b1, 1, 2'b00, 2'd3, 1, 14'h2A5, 5'd2, 5'd3);
        issue(3'd3, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0);
        expect_out("R8 VS without hypervisor is host request", 1'b1, 1, 2'b00, 2'd0, 0, '0, 5'd0, 5'd0);
    endtask

    task automatic t_user_and_bad;
        issue(3'd2, 1'b0, 1'b1, 1'b0, 5'd1, 5'd1);
        expect_out("R6 U illegal", 1'b0, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
        for (int m = 5; m < 8; m++) begin
            issue(3'(m), 1'b0, 1'b1, 1'b0, 5'd1, 5'd0);
            expect_out($sformatf("R6 undefined mode %0d illegal", m), 1'b0, 0, 2'b01, 2'd0, 0, '0, 5'd0, 5'd0);
        end
    endtask

    task automatic t_vu_mode;
        issue(3'd4, 1'b0, 1'b1, 1'b0, 5'd5, 5'd5);
        expect_out("R7 VU with hypervisor virtual", 1'b0, 0, 2'b10, 2'd0, 0, '0, 5'd0, 5'd0);
        issue(3'd4, 1'b1, 1'b0, 1'b1, 5'd5, 5'd0);
        expect_out("R7 VU without hypervisor request", 1'b0, 1, 2'b00, 2'd2, 0, '0, 5'd5, 5'd0);
    endtask

    task automatic t_idle;
        issue(3'd0, 1'b0, 1'b0, 1'b0, 5'd7, 5'd8);
        @(negedge clk);
        expect_out("R10 single-cycle pulse then idle", 1'b0, 0, 2'b00, 2'd0, 0, '0, 5'd0, 5'd0);
        issue(3'd2, 1'b0, 1'b0, 1'b0, 5'd7, 5'd8);
        @(negedge clk);
        expect_out("R10 trap clears after idle", 1'b0, 0, 2'b00, 2'd0, 0, '0, 5'd0, 5'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_scopes();
        t_supervisor();
        t_vs_mode();
        t_user_and_bad();
        t_vu_mode();
        t_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule